// File: doc/BRIEF.md
# Rolling Receive Buffer Writer

This block stores the payload of a received frame in a circular window inside a 256-byte packet RAM. A host can therefore unload frames far longer than the RAM (up to 65535 bytes) half a window at a time. The block is armed by a mode bit. It stays idle until a pulse reports that the sync word was seen. From then on it takes each byte strobed in by the deserializer and writes it to the next RAM location. When it passes the window's last location it wraps back to the window's first location.

There are two interrupt flags. The half-way flag rises when the byte at the programmed signal offset is written; the host then drains the lower part of the window. The full flag rises when the byte at the window's last location is written; the host then drains the upper part. Capture stops after a programmed 16-bit number of bytes, and a one-cycle end-of-frame pulse marks that point. An abort command also stops capture, without the pulse. The block does not detect overruns. If the host falls behind, older data is overwritten and counting goes on.

The window start, window size, signal offset and byte limit are sampled when the sync pulse is accepted. They stay fixed until the frame ends. The byte limit arrives as the two bytes the host keeps at RAM locations 0x14 (low) and 0x15 (high).

Top module: `rb_rx_writer`

## Requirements
- R1: Capture starts only when `syncDet` is high in a cycle with `modeReg` bit 5 set while the block is idle. A sync pulse with bit 5 clear, or a byte strobed while idle, produces no RAM write.
- R2: The RAM write port is registered: a byte accepted at a clock edge appears on `ramWe`/`ramAddr`/`ramWdata` right after that edge. The first byte of a frame goes to the window start, and each later byte goes to the next address.
- R3: The window's last address is start plus size, clamped to 0xFF. After a byte is written there, the next byte goes to the window start.
- R4: `intSrc` bit 5 (half-way flag) is set at the edge that writes the byte at start plus signal offset. If that address lies beyond the window's last address, the flag is never set.
- R5: `intSrc` bit 6 (full flag) is set at the edge that writes the byte at the window's last address. All other `intSrc` bits read 0.
- R6: `irqOut` is high exactly when some `intSrc` bit is set and the matching `intMask` bit is 1. A 1 in `intClr` clears that flag at the next edge. A set and a clear in the same cycle leave the flag set.
- R7: After the limit number of bytes has been accepted, `eofPulse` is high for the one cycle in which the last write is presented, and capture stops. Later bytes are ignored. A limit of 0 gives the pulse right after the sync edge with no write.
- R8: `abortCmd` during capture ends the frame at the next edge without an end-of-frame pulse. A byte strobed in the abort cycle is not written.
- R9: No write is ever issued to addresses 0x00–0x1F. A byte whose address falls there is dropped, but it still advances the pointer and the count.
- R10: Start, size, signal offset and limit are sampled at the sync edge. Changing them during a frame has no effect on that frame.
- R11: When the host falls behind there is no overrun indication: writing wraps and continues over old data until the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReg | input | 8 | Mode configuration; bit 5 arms rolling receive |
| syncDet | input | 1 | One-cycle pulse: sync word detected |
| rxValid | input | 1 | One-cycle strobe: `rxByte` holds a new byte |
| rxByte | input | 8 | Received byte |
| abortCmd | input | 1 | Stop capture now |
| baseReg | input | 8 | Window start address |
| sizeReg | input | 8 | Window size (last address = start + size) |
| sigReg | input | 8 | Half-way signal offset from start |
| lenLo | input | 8 | Byte limit, low byte (RAM location 0x14) |
| lenHi | input | 8 | Byte limit, high byte (RAM location 0x15) |
| intMask | input | 8 | Interrupt mask, one bit per flag |
| intClr | input | 8 | Write-one-to-clear for flags |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 8 | RAM write address |
| ramWdata | output | 8 | RAM write data |
| intSrc | output | 8 | Interrupt flags: bit 6 full, bit 5 half-way |
| irqOut | output | 1 | Masked interrupt line |
| eofPulse | output | 1 | End-of-frame pulse |
| busy | output | 1 | Capture in progress |

## Verification
The embedded properties rely on three input conventions:
- `syncDet` and `rxValid` are single-cycle strobes.
- The byte limit is never exceeded by the counter during a frame.
- Configuration only matters at the sync edge.

The stimulus drives every strobe for exactly one cycle between clock edges. Random windows are drawn with start at or above 0x20 and start plus size within 0xFF, and random signal offsets and limits are kept inside the window and the 16-bit range. Directed frames then leave those bounds on purpose: a window that spills past 0xFF, a start inside the reserved area, a signal offset beyond the window, and a zero limit. They also change the configuration inputs mid-frame, so the sampling rule is exercised.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;   // frame armed, latch configuration
    logic accept;  // store the current byte
    logic finish;  // frame ends at this edge
  } rbStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE    = 1'b0,
    ST_CAPTURE = 1'b1
  } rbState_t;
endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import rb_pkg::*;
#(
  parameter int MODE_W   = 8,
  parameter int MODE_BIT = 5,
  parameter int LEN_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReg,
  input  logic              syncDet,
  input  logic              rxValid,
  input  logic              abortCmd,
  input  logic [LEN_W-1:0]  lenLimit,
  output rbStrobe_t         strobe,
  output logic              busy,
  output logic              eofPulse
);
  rbState_t         state;
  logic [LEN_W-1:0] byteCount;
  logic [LEN_W-1:0] limitQ;
  logic             startEv;
  logic             acceptEv;
  logic             lastByte;
  logic             abortEv;
  logic             zeroLimit;

  always_comb begin
    startEv   = (state == ST_IDLE) && syncDet && modeReg[MODE_BIT];
    zeroLimit = startEv && (lenLimit == '0);
    abortEv   = (state == ST_CAPTURE) && abortCmd;
    acceptEv  = (state == ST_CAPTURE) && rxValid && !abortCmd;
    lastByte  = acceptEv && ((byteCount + LEN_W'(1)) == limitQ);
    strobe.start  = startEv && !zeroLimit;
    strobe.accept = acceptEv;
    strobe.finish = lastByte || abortEv || zeroLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      byteCount <= '0;
      limitQ    <= '0;
      eofPulse  <= 1'b0;
    end else begin
      eofPulse <= lastByte || zeroLimit;
      if (strobe.start) begin
        state     <= ST_CAPTURE;
        byteCount <= '0;
        limitQ    <= lenLimit;
      end else if (lastByte || abortEv) begin
        state <= ST_IDLE;
      end else if (acceptEv) begin
        byteCount <= byteCount + LEN_W'(1);
      end
    end
  end

  assign busy = (state == ST_CAPTURE);

  // R7: the count never reaches the limit while capturing
  assert_count_below_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPTURE) |-> (byteCount < limitQ));

  // R7: an end-of-frame pulse is only seen once capture has stopped
  assert_eof_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    eofPulse |-> (state == ST_IDLE));

  // R8: abort drops to idle without end of frame
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CAPTURE) && abortCmd) |=> ((state == ST_IDLE) && !eofPulse));

  // R1: without the mode bit, sync leaves the block idle
  assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !modeReg[MODE_BIT]) |=> (state == ST_IDLE));
endmodule

// File: rtl/rb_datapath.sv
module rb_datapath
  import rb_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int RESERVED_TOP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] sizeReg,
  input  logic [ADDR_W-1:0] sigReg,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              clrHalf,
  input  logic              clrFull,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              flagHalf,
  output logic              flagFull
);
  localparam int SUM_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] RES_TOP  = ADDR_W'(RESERVED_TOP);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] endQ;
  logic [ADDR_W-1:0] sigAddrQ;
  logic              sigValidQ;
  logic [ADDR_W-1:0] ptrQ;

  logic [SUM_W-1:0]  endSum;
  logic [SUM_W-1:0]  sigSum;
  logic [ADDR_W-1:0] endD;
  logic              atEnd;
  logic              atSig;
  logic              setHalf;
  logic              setFull;

  always_comb begin
    endSum  = {1'b0, baseReg} + {1'b0, sizeReg};
    sigSum  = {1'b0, baseReg} + {1'b0, sigReg};
    endD    = endSum[ADDR_W] ? ADDR_MAX : endSum[ADDR_W-1:0];
    atEnd   = (ptrQ == endQ);
    atSig   = sigValidQ && (ptrQ == sigAddrQ);
    setHalf = strobe.accept && atSig;
    setFull = strobe.accept && atEnd;
  end

  // configuration snapshot and write pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      endQ      <= '0;
      sigAddrQ  <= '0;
      sigValidQ <= 1'b0;
      ptrQ      <= '0;
    end else if (strobe.start) begin
      baseQ     <= baseReg;
      endQ      <= endD;
      sigAddrQ  <= sigSum[ADDR_W-1:0];
      sigValidQ <= (sigSum <= {1'b0, endD});
      ptrQ      <= baseReg;
    end else if (strobe.accept) begin
      ptrQ <= atEnd ? baseQ : ptrQ + ADDR_W'(1);
    end
  end

  // registered RAM write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramWdata <= '0;
    end else begin
      ramWe <= strobe.accept && (ptrQ >= RES_TOP);
      if (strobe.accept) begin
        ramAddr  <= ptrQ;
        ramWdata <= rxByte;
      end
    end
  end

  // interrupt flags, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagHalf <= 1'b0;
      flagFull <= 1'b0;
    end else begin
      flagHalf <= setHalf || (flagHalf && !clrHalf);
      flagFull <= setFull || (flagFull && !clrFull);
    end
  end

  // R9: reserved locations are never written
  assert_no_reserved_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr >= RES_TOP));

  // R3: every write stays inside the latched window
  assert_write_in_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ((ramAddr >= baseQ) && (ramAddr <= endQ)));

  // R3: after the window's last address the pointer returns to the start
  assert_wrap_to_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && atEnd && !strobe.start) |=> (ptrQ == baseQ));

  // R5: full flag rises only with a write presented at the window end
  assert_full_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagFull) |-> (ramAddr == endQ));

  // R6: clear without a set drops the flag
  assert_clear_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrHalf && !setHalf) |=> !flagHalf);
endmodule

// File: rtl/rb_rx_writer.sv
module rb_rx_writer
  import rb_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int LEN_W        = 16,
  parameter int MODE_W       = 8,
  parameter int MODE_BIT     = 5,
  parameter int INT_W        = 8,
  parameter int FULL_BIT     = 6,
  parameter int HALF_BIT     = 5,
  parameter int RESERVED_TOP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeReg,
  input  logic              syncDet,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              abortCmd,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [ADDR_W-1:0] sizeReg,
  input  logic [ADDR_W-1:0] sigReg,
  input  logic [DATA_W-1:0] lenLo,
  input  logic [DATA_W-1:0] lenHi,
  input  logic [INT_W-1:0]  intMask,
  input  logic [INT_W-1:0]  intClr,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic [INT_W-1:0]  intSrc,
  output logic              irqOut,
  output logic              eofPulse,
  output logic              busy
);
  rbStrobe_t        strobe;
  logic [LEN_W-1:0] lenLimit;
  logic             flagHalf;
  logic             flagFull;

  assign lenLimit = LEN_W'({lenHi, lenLo});

  rb_ctrl #(
    .MODE_W  (MODE_W),
    .MODE_BIT(MODE_BIT),
    .LEN_W   (LEN_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeReg (modeReg),
    .syncDet (syncDet),
    .rxValid (rxValid),
    .abortCmd(abortCmd),
    .lenLimit(lenLimit),
    .strobe  (strobe),
    .busy    (busy),
    .eofPulse(eofPulse)
  );

  rb_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .RESERVED_TOP(RESERVED_TOP)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .baseReg (baseReg),
    .sizeReg (sizeReg),
    .sigReg  (sigReg),
    .rxByte  (rxByte),
    .clrHalf (intClr[HALF_BIT]),
    .clrFull (intClr[FULL_BIT]),
    .ramWe   (ramWe),
    .ramAddr (ramAddr),
    .ramWdata(ramWdata),
    .flagHalf(flagHalf),
    .flagFull(flagFull)
  );

  always_comb begin
    intSrc           = '0;
    intSrc[HALF_BIT] = flagHalf;
    intSrc[FULL_BIT] = flagFull;
    irqOut           = |(intSrc & intMask);
  end

  // R2: a write is only presented after a byte accepted during capture
  assert_write_needs_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(busy));

  // R7: no write follows the end-of-frame pulse without a new frame
  assert_quiet_after_eof_R7: assert property (@(posedge clk) disable iff (!rstN)
    (eofPulse && !busy) |=> !ramWe);
endmodule

// File: tb/tb_rb_rx_writer.sv
module tb_rb_rx_writer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modeReg = '0;
  logic       syncDet = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       abortCmd = 1'b0;
  logic [7:0] baseReg = '0, sizeReg = '0, sigReg = '0, lenLo = '0, lenHi = '0;
  logic [7:0] intMask = '0, intClr = '0;
  logic       ramWe;
  logic [7:0] ramAddr, ramWdata, intSrc;
  logic       irqOut, eofPulse, busy;

  rb_rx_writer dut (
    .clk(clk), .rstN(rstN), .modeReg(modeReg), .syncDet(syncDet),
    .rxValid(rxValid), .rxByte(rxByte), .abortCmd(abortCmd),
    .baseReg(baseReg), .sizeReg(sizeReg), .sigReg(sigReg),
    .lenLo(lenLo), .lenHi(lenHi), .intMask(intMask), .intClr(intClr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .intSrc(intSrc), .irqOut(irqOut), .eofPulse(eofPulse), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  int  mBase, mEnd, mSigAddr, mPtr, mLimit, mCount;
  bit  mSigValid, mHalf, mFull, mBusy;

  function automatic int winEnd(int b, int s);
    return (b + s > 255) ? 255 : b + s;
  endfunction

  function automatic int expSrc(bit h, bit f);
    return (int'(f) << 6) | (int'(h) << 5);
  endfunction

  function automatic bit expIrq(bit h, bit f, logic [7:0] m);
    return (h && m[5]) || (f && m[6]);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chkFlags(string req);
    chk({req, " intSrc"}, int'(intSrc), expSrc(mHalf, mFull));
    chk({req, " irqOut"}, int'(irqOut), int'(expIrq(mHalf, mFull, intMask)));
  endtask

  task automatic startFrame(string req, int b, int s, int g, int lim);
    modeReg = 8'h20;
    baseReg = 8'(b); sizeReg = 8'(s); sigReg = 8'(g);
    lenLo = 8'(lim); lenHi = 8'(lim >> 8);
    syncDet = 1;
    step();
    syncDet = 0;
    mBase = b; mEnd = winEnd(b, s); mSigAddr = b + g;
    mSigValid = (b + g) <= mEnd;
    mPtr = b; mLimit = lim; mCount = 0;
    mBusy = (lim != 0);
    chk({req, " busy after sync"}, int'(busy), int'(mBusy));
    chk({req, " eof after sync"}, int'(eofPulse), int'(lim == 0));
    chk({req, " no write at sync"}, int'(ramWe), 0);
  endtask

  task automatic sendByte(string req, logic [7:0] d, logic [7:0] clr);
    bit expWe, expEof, sH, sF;
    int addr;
    rxValid = 1; rxByte = d; intClr = clr;
    step();
    rxValid = 0; intClr = 0;
    expWe = 0; expEof = 0; sH = 0; sF = 0; addr = mPtr;
    if (mBusy) begin
      expWe = (mPtr >= 32);
      sH = mSigValid && (mPtr == mSigAddr);
      sF = (mPtr == mEnd);
      mPtr = sF ? mBase : mPtr + 1;
      mCount++;
      if (mCount == mLimit) begin
        expEof = 1; mBusy = 0;
      end
    end
    mHalf = sH || (mHalf && !clr[5]);
    mFull = sF || (mFull && !clr[6]);
    chk({req, " ramWe"}, int'(ramWe), int'(expWe));
    if (expWe) begin
      chk({req, " ramAddr"}, int'(ramAddr), addr);
      chk({req, " ramWdata"}, int'(ramWdata), int'(d));
    end
    chk({req, " eofPulse"}, int'(eofPulse), int'(expEof));
    chk({req, " busy"}, int'(busy), int'(mBusy));
    chkFlags(req);
  endtask

  task automatic clearAll();
    intClr = 8'hFF;
    step();
    intClr = 0;
    mHalf = 0; mFull = 0;
    chkFlags("R6 clear");
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    mHalf = 0; mFull = 0; mBusy = 0;
    repeat (3) step();
    rstN = 1;
    step();
    // reset state
    chk("R2 reset ramWe", int'(ramWe), 0);
    chk("R5 reset intSrc", int'(intSrc), 0);
    chk("R6 reset irqOut", int'(irqOut), 0);
    chk("R7 reset eof", int'(eofPulse), 0);
    chk("R1 reset busy", int'(busy), 0);

    // R1: bytes before sync and sync without mode bit are ignored
    intMask = 8'h60;
    sendByte("R1 pre-sync byte", 8'h11, 0);
    modeReg = 8'hDF; baseReg = 8'h40; sizeReg = 8'h10; lenLo = 8'h05; lenHi = 0;
    syncDet = 1; step(); syncDet = 0;
    chk("R1 mode bit clear", int'(busy), 0);
    sendByte("R1 unarmed byte", 8'h22, 0);

    // R2 R3 R4 R5: small window, several wraps (R11 overwrite)
    startFrame("R2", 8'h40, 3, 1, 11);
    for (int i = 0; i < 11; i++) sendByte("R11 wrap", 8'(8'hA0 + i), 0);
    sendByte("R7 after eof", 8'h5A, 0);
    clearAll();

    // R6: set and clear in the same cycle, set wins
    intMask = 8'h20;
    startFrame("R6", 8'h30, 4, 0, 3);
    sendByte("R6 set wins", 8'h01, 8'h20);
    sendByte("R6 mask", 8'h02, 8'h40);
    sendByte("R6 last", 8'h03, 8'h00);
    clearAll();
    intMask = 8'h60;

    // R7: zero limit
    startFrame("R7 zero limit", 8'h50, 8, 4, 0);
    sendByte("R7 zero limit byte", 8'h77, 0);

    // R8: abort mid-frame, byte in abort cycle dropped
    startFrame("R8", 8'h60, 8, 4, 20);
    for (int i = 0; i < 3; i++) sendByte("R8 before abort", 8'(i), 0);
    abortCmd = 1; rxValid = 1; rxByte = 8'hEE;
    step();
    abortCmd = 0; rxValid = 0; mBusy = 0;
    chk("R8 abort ramWe", int'(ramWe), 0);
    chk("R8 abort busy", int'(busy), 0);
    chk("R8 abort no eof", int'(eofPulse), 0);
    sendByte("R8 after abort", 8'h44, 0);
    clearAll();

    // R3: window past 0xFF clamps, signal offset beyond window never fires (R4)
    startFrame("R3 clamp", 8'hF8, 8'h20, 8'h10, 20);
    for (int i = 0; i < 20; i++) sendByte("R3 clamp", 8'(i * 3), 0);
    chk("R4 unreachable offset", int'(intSrc[5]), 0);
    clearAll();

    // R9: window starting inside reserved area
    startFrame("R9", 8'h18, 8'h10, 8'h02, 40);
    for (int i = 0; i < 40; i++) sendByte("R9 reserved", 8'(i), 0);
    clearAll();

    // R10: configuration changes during a frame have no effect
    startFrame("R10", 8'h80, 8'h0F, 8'h07, 30);
    baseReg = 8'h22; sizeReg = 8'h02; sigReg = 8'h00; lenLo = 8'h02; lenHi = 8'h00;
    modeReg = 8'h00;
    for (int i = 0; i < 30; i++) sendByte("R10 held config", 8'(8'hC0 + i), 0);
    clearAll();

    // long limit crossing the low byte (R7 high byte used)
    startFrame("R7 long", 8'h20, 8'hDF, 8'h6F, 300);
    for (int i = 0; i < 300; i++) sendByte("R7 long", 8'($urandom), 0);
    clearAll();

    // random frames
    for (int f = 0; f < 20; f++) begin
      int b, s, g, lim;
      b = 32 + int'($urandom % 192);
      s = int'($urandom % (256 - b));
      g = int'($urandom % (s + 1));
      lim = 1 + int'($urandom % 400);
      intMask = 8'($urandom) & 8'h60;
      startFrame("R2 random", b, s, g, lim);
      for (int i = 0; i < lim; i++) begin
        logic [7:0] c;
        c = (($urandom % 8) == 0) ? (8'($urandom) & 8'h60) : 8'h00;
        sendByte("R4 R5 random", 8'($urandom), c);
        for (int k = 0; k < int'($urandom % 3); k++) begin
          step();
          chk("R2 idle gap", int'(ramWe), 0);
        end
      end
      sendByte("R7 random after eof", 8'h99, 0);
      clearAll();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule